// File: doc/BRIEF.md
# Halfword-to-byte width downconverter

This block turns 16-bit parallel words into an 8-bit output stream that runs at the byte clock, two bytes for each word. A word is offered on the data input with a load strobe. When the block is idle, enabled, and sees the strobe, it captures the word into a holding register. The high byte leaves on the next clock edge and the low byte leaves on the edge after that. A phase counter drives a lane selector that picks one byte of the word, and a register on the output makes every byte change only on a rising edge.

The enable input gates the whole conversion. While the enable is low, the phase counter and the output byte keep their values and the valid flag drops. When the enable comes back, a word that was half sent resumes from where it stopped. If a new load is presented every time the counter returns to phase 0, the output carries a valid byte on every cycle with no gap. A load strobe is ignored when it arrives while the low byte is still pending or while the enable is low.

Top module: `wdc_downconv`

## Requirements
- R1: While rst_ni is low and after it is released, byte_o is 0, valid_o is 0 and the phase counter is at 0.
- R2: When en_i is high, the phase is 0 and load_i is high at a rising edge, byte_o after that edge equals data_i[15:8] and valid_o is 1.
- R3: At the next rising edge after the one in R2 at which en_i is high, byte_o becomes data_i[7:0] of the captured word and valid_o is 1. The phase then returns to 0.
- R4: A load_i pulse during phase 1 is ignored. The low byte that is sent is the one from the word captured earlier, and the ignored word is never sent.
- R5: While en_i is low, valid_o is 0 after each edge, byte_o keeps its value and the phase does not change. A word that was half sent resumes with its low byte once en_i is high again.
- R6: When en_i is high, the phase is 0 and load_i is low, valid_o is 0 after the edge and byte_o keeps its value.
- R7: A load_i pulse while en_i is low captures nothing. A later enabled cycle without load_i sends no byte.
- R8: With en_i held high and load_i presented at every phase-0 edge, valid_o stays 1 on every cycle, and the bytes alternate high then low for each word in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Conversion enable |
| load_i | input | 1 | Word load strobe |
| data_i | input | 16 | Parallel input word |
| byte_o | output | 8 | Registered output byte |
| valid_o | output | 1 | Output byte valid |

## Verification
The bench covers the following corner cases, each with the symptom a faulty design would show:
- **Enable drops between the two bytes of a word.** A design that lets the phase advance while disabled would skip the low byte or repeat the high one.
- **Load strobe during phase 1.** A design that captures at every load would send the wrong low byte.
- **Load strobe while disabled.** A design that latches it would produce a stray byte later.
- **Back-to-back loads.** These expose a bubble between words or a swapped byte order.

Random mixes of enable, load and data fill in the rest of the state space. Each result is compared against a cycle model that the bench builds from the requirements.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_LANES  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_HOLD = 2'd2
  } step_e;
endpackage

// File: rtl/wdc_phase_ctr.sv
module wdc_phase_ctr #(
  parameter int unsigned LANES = 2,
  localparam int unsigned PH_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [PH_W-1:0] ph_o,
  output logic            first_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(LANES - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (adv_i) begin
      if (ph_q == LAST) ph_q <= '0;
      else              ph_q <= ph_q + 1'b1;
    end
  end

  assign ph_o    = ph_q;
  assign first_o = (ph_q == '0);

  p_phase_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ph_q));

  p_phase_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && ph_q == LAST) |=> (ph_q == '0));

  always_comb begin
    if (rst_ni) p_phase_range_r4: assert (int'(ph_q) < int'(LANES));
  end
endmodule

// File: rtl/wdc_lane_sel.sv
module wdc_lane_sel #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned PH_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [PH_W-1:0]   sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lane [LANES];

  // lane 0 is the most significant byte: sent first
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[WORD_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    byte_o = lane[0];
    for (int i = 0; i < LANES; i++) begin
      if (int'(sel_i) == i) byte_o = lane[i];
    end
  end
endmodule

// File: rtl/wdc_out_reg.sv
module wdc_out_reg #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              emit_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i & emit_i;
      if (en_i && emit_i) byte_o <= byte_i;
    end
  end

  p_idle_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && emit_i) |=> (!valid_o && $stable(byte_o)));
endmodule

// File: rtl/wdc_downconv.sv
module wdc_downconv
  import wdc_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned PH_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  logic [PH_W-1:0]   ph;
  logic              first;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] src;
  logic [BYTE_W-1:0] sel_byte;
  logic              take;
  logic              emit;
  step_e             step;

  assign take = en_i & first & load_i;

  always_comb begin
    if (!en_i)                step = ST_HOLD;
    else if (!first || load_i) step = ST_EMIT;
    else                      step = ST_IDLE;
  end
  assign emit = (step == ST_EMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (take) hold_q <= data_i;
  end

  // phase 0 sends straight from the word being captured
  assign src = first ? data_i : hold_q;

  wdc_phase_ctr #(.LANES(LANES)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (emit),
    .ph_o   (ph),
    .first_o(first)
  );

  wdc_lane_sel #(.BYTE_W(BYTE_W), .LANES(LANES)) u_sel (
    .word_i(src),
    .sel_i (ph),
    .byte_o(sel_byte)
  );

  wdc_out_reg #(.BYTE_W(BYTE_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .emit_i (emit),
    .byte_i (sel_byte),
    .byte_o (byte_o),
    .valid_o(valid_o)
  );

  p_first_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && first && load_i) |=> (valid_o && byte_o == $past(data_i[WORD_W-1 -: BYTE_W])));

  p_pending_sent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !first) |=> valid_o);

  p_disabled_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!valid_o && $stable(byte_o)));

  p_no_load_no_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && first && !load_i) |=> !valid_o);
endmodule

// File: tb/wdc_downconv_bench.sv
module wdc_downconv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [15:0] data = '0;
  logic [7:0]  byte_q;
  logic        valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference state
  bit          m_ph;
  logic [15:0] m_hold;
  logic [7:0]  m_byte;
  bit          m_valid;

  always #5 clk = ~clk;

  wdc_downconv u_wdc_downconv (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .load_i (load),
    .data_i (data),
    .byte_o (byte_q),
    .valid_o(valid)
  );

  function automatic string auto_tag(bit e, bit l, bit ph);
    if (!e)     return "R5";
    if (ph)     return "R3";
    if (l)      return "R2";
    return "R6";
  endfunction

  task automatic check(string tag);
    n_checks++;
    if (valid !== m_valid || (m_valid && byte_q !== m_byte) || (!m_valid && byte_q !== m_byte)) begin
      n_fail++;
      $display("FAIL %s: byte=%h valid=%b expected byte=%h valid=%b", tag, byte_q, valid, m_byte, m_valid);
    end
  endtask

  task automatic step(bit e, bit l, logic [15:0] d, string tag = "");
    string t;
    t = (tag == "") ? auto_tag(e, l, m_ph) : tag;
    en = e; load = l; data = d;
    @(posedge clk);
    if (e) begin
      if (!m_ph) begin
        if (l) begin
          m_hold = d; m_byte = d[15:8]; m_valid = 1'b1; m_ph = 1'b1;
        end else m_valid = 1'b0;
      end else begin
        m_byte = m_hold[7:0]; m_valid = 1'b1; m_ph = 1'b0;
      end
    end else m_valid = 1'b0;
    @(negedge clk);
    check(t);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    m_ph = 1'b0; m_hold = '0; m_byte = '0; m_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    step(1, 1, 16'hA55A, "R2");
    step(1, 0, 16'h0000, "R3");
    step(1, 0, 16'h1234, "R6");
    // enable drop mid-word
    step(1, 1, 16'hBEEF, "R2");
    step(0, 1, 16'h1111, "R5");
    step(0, 0, 16'h2222, "R5");
    step(1, 0, 16'h3333, "R5");
    // load in phase 1 is ignored
    step(1, 1, 16'hC0DE, "R2");
    step(1, 1, 16'hFFFF, "R4");
    step(1, 0, 16'h0000, "R4");
    // load while disabled
    step(0, 1, 16'h7E7E, "R7");
    step(1, 0, 16'h0000, "R7");
    // back-to-back words
    for (int w = 0; w < 6; w++) begin
      logic [15:0] d;
      d = 16'(w * 16'h1357 + 16'h0F0F);
      step(1, 1, d, "R8");
      step(1, 0, 16'h0, "R8");
    end
    for (int i = 0; i < 400; i++) begin
      bit e, l;
      e = ($urandom % 4) != 0;
      l = ($urandom % 3) != 0;
      step(e, l, 16'($urandom));
    end
    // reset mid-word returns to idle
    step(1, 1, 16'h4242, "R2");
    rst_n = 1'b0;
    m_ph = 1'b0; m_hold = '0; m_byte = '0; m_valid = 1'b0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step(1, 0, 16'h0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule